// File: doc/BRIEF.md
# Enabled OR-Tree Concentrator Bus

This block merges several signal groups onto one shared output bus. Each group comes from one IP block and is already packed by an earlier stage, so it is at most as wide as the bus. Every group has its own row of enable bits, one bit for each bus lane. A group's bit reaches a lane only when the enable bit for that group and lane is set. The gated bits from all groups are combined by a tree of two-input OR gates, and the result is registered. Because the gating is done with local AND gates, the selection state sits next to the bus and is not spread across the chip.

Software fills the enable rows so that each group starts at the first free lane. The total number of selected signals may not exceed the bus width. Any such subset of inputs can then reach the bus, although their order on the bus cannot be chosen. When two groups are enabled on the same lane, the block sets a sticky flag. Software can read this flag and clear it.

Top module: `concbus_top`

## Requirements
- R1: While reset is asserted and immediately after it is released, the bus output is all zeros, every enable bit is zero (the readback of every row is 0) and the overlap flag is low.
- R2: When `cfg_we` is high on a rising edge, `cfg_bits` replaces the enable row of group `cfg_sel`. `rd_bits` continuously shows the enable row of group `rd_sel`, and other rows are left unchanged.
- R3: Bit p of group g is taken from `grp_data[g*LANES + p]` and can affect only bus lane p. It reaches that lane only when enable bit p of row g is 1. A group whose row is all zeros has no effect on the bus.
- R4: Groups enabled on disjoint lanes are merged onto the bus, so each lane carries the bit of the group enabled there.
- R5: The bus is registered and updates on every clock edge. A change on `grp_data` or on the enables appears on `bus_q` after exactly one rising edge, and not before.
- R6: When any lane has two or more groups enabled, `overlap_flag` goes high on the next rising edge.
- R7: `overlap_flag` stays high after the overlapping configuration is removed, until it is cleared.
- R8: A high `overlap_clr` on a rising edge forces the flag low, taking priority over a new overlap. If the overlap is still configured, the flag returns high on the following edge.
- R9: On a lane where several groups are enabled, the bus carries the OR of those groups' bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grp_data | input | GROUPS*LANES | Packed group inputs; group g occupies bits [g*LANES +: LANES] |
| cfg_we | input | 1 | Enable-row write strobe |
| cfg_sel | input | SEL_W | Group index of the row being written |
| cfg_bits | input | LANES | New enable row |
| rd_sel | input | SEL_W | Group index of the row being read back |
| rd_bits | output | LANES | Enable row of group `rd_sel` |
| overlap_clr | input | 1 | Clears the sticky overlap flag |
| overlap_flag | output | 1 | Sticky flag: two groups were enabled on one lane |
| bus_q | output | LANES | Registered concentrated bus |

## Verification
The bench fixes a disjoint packing (group 0 on lanes 0-1, group 1 on lanes 2-4, group 2 off, group 3 on lanes 5-7). It then applies all-ones, all-zeros and single-group floods. A flood on the disabled group shows that the gating holds, and a flood on one active group shows that no bit leaks into lanes owned by another group. Alternating patterns such as A5/5A and an irregular word show that each lane follows only its owner's bit and does not mirror a neighbour's. A deliberate overlap on lane 0 tests the OR merge and the rules for setting, holding and clearing the sticky flag. A one-cycle probe before the clock edge separates a registered path from a combinational one.

// File: rtl/concbus_pkg.sv
package concbus_pkg;
  localparam int unsigned DEF_GROUPS = 4;
  localparam int unsigned DEF_LANES  = 8;

  function automatic int unsigned sel_width(input int unsigned groups);
    return (groups > 1) ? $clog2(groups) : 1;
  endfunction

  function automatic int unsigned tree_depth(input int unsigned groups);
    return (groups > 1) ? $clog2(groups) : 0;
  endfunction
endpackage

// File: rtl/concbus_en_store.sv
module concbus_en_store
  import concbus_pkg::*;
#(
  parameter int unsigned GROUPS = DEF_GROUPS,
  parameter int unsigned LANES  = DEF_LANES,
  localparam int unsigned SEL_W = sel_width(GROUPS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [SEL_W-1:0]        wr_sel,
  input  logic [LANES-1:0]        wr_bits,
  input  logic [SEL_W-1:0]        rd_sel,
  output logic [LANES-1:0]        rd_bits,
  output logic [GROUPS*LANES-1:0] en_flat
);
  logic [LANES-1:0] row_q [GROUPS];
  logic [LANES-1:0] row_d [GROUPS];
  logic [GROUPS-1:0] row_ce;

  for (genvar g = 0; g < GROUPS; g++) begin : g_row
    always_comb begin
      row_ce[g] = wr_en && (int'(wr_sel) == g);
      row_d[g]  = wr_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        row_q[g] <= '0;
      end else if (row_ce[g]) begin
        row_q[g] <= row_d[g];
      end
    end

    assign en_flat[g*LANES +: LANES] = row_q[g];
  end

  always_comb begin
    rd_bits = '0;
    for (int g = 0; g < GROUPS; g++) begin
      if (int'(rd_sel) == g) rd_bits = row_q[g];
    end
  end
endmodule

// File: rtl/concbus_gate.sv
module concbus_gate
  import concbus_pkg::*;
#(
  parameter int unsigned GROUPS = DEF_GROUPS,
  parameter int unsigned LANES  = DEF_LANES
) (
  input  logic [GROUPS*LANES-1:0] data_flat,
  input  logic [GROUPS*LANES-1:0] en_flat,
  output logic [GROUPS*LANES-1:0] gated_flat
);
  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    for (genvar p = 0; p < LANES; p++) begin : g_lane
      assign gated_flat[g*LANES + p] = data_flat[g*LANES + p] & en_flat[g*LANES + p];
    end
  end
endmodule

// File: rtl/concbus_or_tree.sv
module concbus_or_tree
  import concbus_pkg::*;
#(
  parameter int unsigned GROUPS = DEF_GROUPS,
  parameter int unsigned LANES  = DEF_LANES
) (
  input  logic [GROUPS*LANES-1:0] leaf_flat,
  output logic [LANES-1:0]        root
);
  localparam int unsigned DEPTH  = tree_depth(GROUPS);
  localparam int unsigned LEAVES = 1 << DEPTH;

  for (genvar l = 0; l <= DEPTH; l++) begin : lv
    localparam int unsigned NODES = LEAVES >> l;
    logic [LANES-1:0] v [NODES];
    if (l == 0) begin : g_leaf
      for (genvar j = 0; j < NODES; j++) begin : g_j
        if (j < GROUPS) begin : g_real
          assign v[j] = leaf_flat[j*LANES +: LANES];
        end else begin : g_pad
          assign v[j] = '0;
        end
      end
    end else begin : g_node
      for (genvar j = 0; j < NODES; j++) begin : g_j
        assign v[j] = lv[l-1].v[2*j] | lv[l-1].v[2*j+1];
      end
    end
  end

  assign root = lv[DEPTH].v[0];
endmodule

// File: rtl/concbus_overlap.sv
module concbus_overlap
  import concbus_pkg::*;
#(
  parameter int unsigned GROUPS = DEF_GROUPS,
  parameter int unsigned LANES  = DEF_LANES
) (
  input  logic [GROUPS*LANES-1:0] en_flat,
  output logic                    overlap
);
  logic [LANES-1:0] seen;
  logic [LANES-1:0] dup;

  always_comb begin
    seen = '0;
    dup  = '0;
    for (int g = 0; g < GROUPS; g++) begin
      dup  = dup | (seen & en_flat[g*LANES +: LANES]);
      seen = seen | en_flat[g*LANES +: LANES];
    end
    overlap = |dup;
  end
endmodule

// File: rtl/concbus_top.sv
module concbus_top
  import concbus_pkg::*;
#(
  parameter int unsigned GROUPS = DEF_GROUPS,
  parameter int unsigned LANES  = DEF_LANES,
  localparam int unsigned SEL_W = sel_width(GROUPS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [GROUPS*LANES-1:0] grp_data,
  input  logic                    cfg_we,
  input  logic [SEL_W-1:0]        cfg_sel,
  input  logic [LANES-1:0]        cfg_bits,
  input  logic [SEL_W-1:0]        rd_sel,
  output logic [LANES-1:0]        rd_bits,
  input  logic                    overlap_clr,
  output logic                    overlap_flag,
  output logic [LANES-1:0]        bus_q
);
  logic [GROUPS*LANES-1:0] en_flat;
  logic [GROUPS*LANES-1:0] gated_flat;
  logic [LANES-1:0]        bus_d;
  logic                    overlap_now;
  logic                    flag_d;

  concbus_en_store #(.GROUPS(GROUPS), .LANES(LANES)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_sel  (cfg_sel),
    .wr_bits (cfg_bits),
    .rd_sel  (rd_sel),
    .rd_bits (rd_bits),
    .en_flat (en_flat)
  );

  concbus_gate #(.GROUPS(GROUPS), .LANES(LANES)) u_gate (
    .data_flat  (grp_data),
    .en_flat    (en_flat),
    .gated_flat (gated_flat)
  );

  concbus_or_tree #(.GROUPS(GROUPS), .LANES(LANES)) u_tree (
    .leaf_flat (gated_flat),
    .root      (bus_d)
  );

  concbus_overlap #(.GROUPS(GROUPS), .LANES(LANES)) u_ovl (
    .en_flat (en_flat),
    .overlap (overlap_now)
  );

  always_comb begin
    if (overlap_clr) flag_d = 1'b0;
    else             flag_d = overlap_flag | overlap_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_q        <= '0;
      overlap_flag <= 1'b0;
    end else begin
      bus_q        <= bus_d;
      overlap_flag <= flag_d;
    end
  end
endmodule

// File: rtl/concbus_chk.sv
module concbus_chk
  import concbus_pkg::*;
#(
  parameter int unsigned GROUPS = DEF_GROUPS,
  parameter int unsigned LANES  = DEF_LANES,
  localparam int unsigned SEL_W = sel_width(GROUPS)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [GROUPS*LANES-1:0] grp_data,
  input logic [GROUPS*LANES-1:0] en_flat,
  input logic                    cfg_we,
  input logic [SEL_W-1:0]        cfg_sel,
  input logic [LANES-1:0]        cfg_bits,
  input logic [SEL_W-1:0]        rd_sel,
  input logic [LANES-1:0]        rd_bits,
  input logic                    overlap_clr,
  input logic                    overlap_flag,
  input logic [LANES-1:0]        bus_q
);
  logic [LANES-1:0] any_data;
  logic [LANES-1:0] any_en;
  logic             multi_en;

  always_comb begin
    any_data = '0;
    any_en   = '0;
    multi_en = 1'b0;
    for (int g = 0; g < GROUPS; g++) begin
      any_data = any_data | grp_data[g*LANES +: LANES];
      for (int p = 0; p < LANES; p++) begin
        if (any_en[p] && en_flat[g*LANES + p]) multi_en = 1'b1;
      end
      any_en = any_en | en_flat[g*LANES +: LANES];
    end
  end

  // R3 / R5: a lane can be high only if some group carried a 1 there on an enabled lane one cycle ago
  assert_bus_subset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_q & ~($past(any_data) & $past(any_en))) == '0);

  // R2: a written row reads back on the next cycle
  assert_row_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_we) && rd_sel == $past(cfg_sel)) |-> rd_bits == $past(cfg_bits));

  // R6: the flag rises only after an overlapping configuration
  assert_flag_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overlap_flag) |-> $past(multi_en));

  // R7: the flag holds until it is cleared
  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(overlap_flag) && !$past(overlap_clr)) |-> overlap_flag);

  // R8: a clear wins on its edge
  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(overlap_clr) |-> !overlap_flag);

  // R6: an overlap without a clear sets the flag
  assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(multi_en) && !$past(overlap_clr)) |-> overlap_flag);
endmodule

bind concbus_top concbus_chk #(.GROUPS(GROUPS), .LANES(LANES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .grp_data     (grp_data),
  .en_flat      (en_flat),
  .cfg_we       (cfg_we),
  .cfg_sel      (cfg_sel),
  .cfg_bits     (cfg_bits),
  .rd_sel       (rd_sel),
  .rd_bits      (rd_bits),
  .overlap_clr  (overlap_clr),
  .overlap_flag (overlap_flag),
  .bus_q        (bus_q)
);

// File: tb/sim_concbus_top.sv
module sim_concbus_top;
  localparam int G = 4;
  localparam int M = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [G*M-1:0] grp_data = '0;
  logic         cfg_we = 1'b0;
  logic [1:0]   cfg_sel = '0;
  logic [M-1:0] cfg_bits = '0;
  logic [1:0]   rd_sel = '0;
  logic [M-1:0] rd_bits;
  logic         overlap_clr = 1'b0;
  logic         overlap_flag;
  logic [M-1:0] bus_q;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  concbus_top #(.GROUPS(G), .LANES(M)) u0 (
    .clk(clk), .rst_n(rst_n), .grp_data(grp_data), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_bits(cfg_bits), .rd_sel(rd_sel), .rd_bits(rd_bits),
    .overlap_clr(overlap_clr), .overlap_flag(overlap_flag), .bus_q(bus_q)
  );

  // {group data (g3,g2,g1,g0), expected bus}; packing g0=03 g1=1C g2=00 g3=E0 (R3, R4)
  localparam logic [39:0] VEC [9] = '{
    {32'hFFFF_FFFF, 8'hFF},
    {32'h0000_0000, 8'h00},
    {32'h00FF_0000, 8'h00},
    {32'h0000_00FF, 8'h03},
    {32'h0000_FF00, 8'h1C},
    {32'hFF00_0000, 8'hE0},
    {32'hA5A5_A5A5, 8'hA5},
    {32'h5A5A_5A5A, 8'h5A},
    {32'h1234_5678, 8'h14}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_row(input int g, input logic [M-1:0] bits);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'(g); cfg_bits = bits;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    finish_run();
  end

  initial begin
    logic [7:0] exp_rows [4];
    exp_rows = '{8'h03, 8'h1C, 8'h00, 8'hE0};
    grp_data = '1;
    repeat (3) @(negedge clk);
    check(bus_q == '0, "R1 bus in reset", 32'(bus_q), 0);
    check(overlap_flag == 1'b0, "R1 flag in reset", 32'(overlap_flag), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(bus_q == '0, "R1 bus after reset", 32'(bus_q), 0);
    for (int g = 0; g < G; g++) begin
      rd_sel = 2'(g); #1;
      check(rd_bits == '0, "R1 enables zero", 32'(rd_bits), 0);
    end

    write_row(0, 8'h03);
    write_row(1, 8'h1C);
    write_row(3, 8'hE0);
    for (int g = 0; g < G; g++) begin
      rd_sel = 2'(g); #1;
      check(rd_bits == exp_rows[g], "R2 row readback", 32'(rd_bits), 32'(exp_rows[g]));
    end
    check(overlap_flag == 1'b0, "R6 disjoint no flag", 32'(overlap_flag), 0);

    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      grp_data = VEC[i][39:8];
      @(negedge clk);
      check(bus_q == VEC[i][7:0], "R3 R4 table", 32'(bus_q), 32'(VEC[i][7:0]));
    end

    // R5: no change before the edge, change after exactly one edge
    @(negedge clk);
    grp_data = 32'h0000_0000;
    @(negedge clk);
    check(bus_q == 8'h00, "R5 settle", 32'(bus_q), 0);
    @(posedge clk); #1;
    grp_data = 32'hFFFF_FFFF;
    #1;
    check(bus_q == 8'h00, "R5 not combinational", 32'(bus_q), 0);
    @(negedge clk);
    check(bus_q == 8'h00, "R5 before edge", 32'(bus_q), 0);
    @(negedge clk);
    check(bus_q == 8'hFF, "R5 one edge later", 32'(bus_q), 32'hFF);

    // R6: overlap on lane 0 (groups 0 and 2)
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd2; cfg_bits = 8'h01;
    grp_data = 32'h0001_0000;
    @(negedge clk);
    cfg_we = 1'b0;
    check(overlap_flag == 1'b0, "R6 not before edge", 32'(overlap_flag), 0);
    check(bus_q == 8'h00, "R5 enable takes one edge", 32'(bus_q), 0);
    @(negedge clk);
    check(overlap_flag == 1'b1, "R6 flag set", 32'(overlap_flag), 1);
    check(bus_q == 8'h01, "R9 OR of overlapping groups", 32'(bus_q), 32'h01);
    grp_data = 32'h0001_00FE;
    @(negedge clk);
    check(bus_q == 8'h03, "R9 OR with both", 32'(bus_q), 32'h03);

    // R8: clear wins, then the flag returns
    overlap_clr = 1'b1;
    @(negedge clk);
    overlap_clr = 1'b0;
    check(overlap_flag == 1'b0, "R8 clear wins", 32'(overlap_flag), 0);
    @(negedge clk);
    check(overlap_flag == 1'b1, "R8 re-set while overlapping", 32'(overlap_flag), 1);

    // R7: removing the overlap keeps the flag
    write_row(2, 8'h00);
    repeat (3) @(negedge clk);
    check(overlap_flag == 1'b1, "R7 sticky", 32'(overlap_flag), 1);
    overlap_clr = 1'b1;
    @(negedge clk);
    overlap_clr = 1'b0;
    repeat (3) @(negedge clk);
    check(overlap_flag == 1'b0, "R8 stays clear", 32'(overlap_flag), 0);

    // R3: disabled group 2 has no effect
    grp_data = 32'h00FF_0000;
    @(negedge clk);
    check(bus_q == 8'h00, "R3 disabled group", 32'(bus_q), 0);

    // R1: reset mid-run
    rst_n = 1'b0;
    #1;
    check(bus_q == '0 && overlap_flag == 1'b0, "R1 async reset", 32'({overlap_flag, bus_q}), 0);
    rd_sel = 2'd3; #1;
    check(rd_bits == '0, "R1 enables cleared", 32'(rd_bits), 0);
    finish_run();
  end
endmodule